// File: doc/BRIEF.md
# Banked Interrupt Aggregator

The block gathers interrupt events from several groups ("banks") of general-purpose pins and reduces each bank to one request line. Each bank keeps a sticky per-pin pending register, an enable mask, and a masked view of the two. A shared per-bank gate decides whether that bank's request reaches the interrupt controller. Bit n of every per-bank register corresponds to pin n of that bank.

Software configures the block through a simple word-addressed register port. Enables are only changed through separate set and clear addresses, so no read-modify-write sequence is needed. Pending bits are acknowledged by writing ones. A pending bit records its event even while its enable is off. A handler can therefore inspect the raw pending state and clear it before it unmasks a pin.

Register map (word addresses): bank b uses addresses 4*b+0 (pending), 4*b+1 (enable set), 4*b+2 (enable clear) and 4*b+3 (masked result). The bank-gate register is at address 4*NUM_BANKS. Other addresses read as zero and ignore writes.

Top module: `irq_bank_agg`

## Requirements
- R1: After reset, every pending, enable and bank-gate bit is 0, all registers read 0, and every request output is low.
- R2: An event on pin n of bank b (evt_i bit b*32+n high on a clock edge) sets pending bit n of bank b (address 4*b+0), whether or not enable bit n is set.
- R3: Writing to the pending address clears each bit written as 1 and leaves each bit written as 0 unchanged. Writing all ones clears every pending bit of that bank.
- R4: When an event and a clear-by-write hit the same pending bit on the same edge, the bit stays set.
- R5: Writing 1 to bit n of the enable-set address (4*b+1) sets enable bit n. Writing 1 to bit n of the enable-clear address (4*b+2) clears it. Bits written as 0 are unchanged, and both addresses read back the current enable mask.
- R6: The result address (4*b+3) reads pending AND enable, and writes to it have no effect.
- R7: Bit b of the bank-gate register (address 4*NUM_BANKS) belongs to bank b. irq_o[b] is high exactly when that bit is set and the bank's result is nonzero.
- R8: If clearing one pending bit leaves other result bits set, irq_o stays high with no gap. It falls in the cycle after the last result bit is cleared.
- R9: Banks are independent. Events, writes and gate bits of one bank never change another bank's state or request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | ADDR_W | Word address |
| reg_wdata_i | input | BANK_W | Write data |
| reg_rdata_o | output | BANK_W | Read data for reg_addr_i (combinational) |
| evt_i | input | NUM_BANKS*BANK_W | Per-pin event strobes, bank-major |
| irq_o | output | NUM_BANKS | Per-bank aggregated request |

## Verification
The bench latches events with the enable off. A design that masks before latching would lose them and read zero pending. It collides an event with a clear of the same bit, which a design that gives the clear priority would drop. It writes zeros to the pending and enable addresses, where a plain-store implementation would wipe unrelated bits. It also clears one of two enabled pending bits and watches for a spurious low on the request. Finally, it drives one bank while checking the other, to catch cross-bank decoding errors.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned REGS_PER_BANK = 4;
  localparam int unsigned OFF_SRC = 0;
  localparam int unsigned OFF_SET = 1;
  localparam int unsigned OFF_CLR = 2;
  localparam int unsigned OFF_RES = 3;
endpackage

// File: rtl/irq_agg_bank.sv
module irq_agg_bank
  import irq_agg_pkg::*;
#(
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned BANK_IDX  = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BANK_W-1:0] reg_wdata_i,
  input  logic [BANK_W-1:0] evt_i,
  input  logic              gate_i,
  output logic [BANK_W-1:0] src_o,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] res_o,
  output logic              irq_o
);
  localparam int unsigned BASE = BANK_IDX * REGS_PER_BANK;

  logic [BANK_W-1:0] src_q, en_q;
  logic we_src, we_set, we_clr;
  logic [BANK_W-1:0] ack_mask, set_mask, clr_mask;

  assign we_src = reg_we_i && (int'(reg_addr_i) == BASE + OFF_SRC);
  assign we_set = reg_we_i && (int'(reg_addr_i) == BASE + OFF_SET);
  assign we_clr = reg_we_i && (int'(reg_addr_i) == BASE + OFF_CLR);

  assign ack_mask = we_src ? reg_wdata_i : '0;
  assign set_mask = we_set ? reg_wdata_i : '0;
  assign clr_mask = we_clr ? reg_wdata_i : '0;

  // event wins over a same-cycle acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) src_q <= '0;
    else         src_q <= (src_q & ~ack_mask) | evt_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= (en_q | set_mask) & ~clr_mask;
  end

  assign src_o = src_q;
  assign en_o  = en_q;
  assign res_o = src_q & en_q;
  assign irq_o = gate_i && (|res_o);

  a_r2_evt_latches: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((src_q & $past(evt_i)) == $past(evt_i)));
  a_r3_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((src_q & ~$past(src_q) & ~$past(evt_i)) == '0));
  a_r5_set_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_set |=> ((en_q & $past(reg_wdata_i)) == $past(reg_wdata_i)));
  a_r5_clr_applies: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_clr |=> ((en_q & $past(reg_wdata_i)) == '0));
  a_r6_en_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!we_set && !we_clr) |=> $stable(en_q));
endmodule

// File: rtl/irq_agg_gate.sv
module irq_agg_gate #(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned GATE_ADDR = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 reg_we_i,
  input  logic [ADDR_W-1:0]    reg_addr_i,
  input  logic [BANK_W-1:0]    reg_wdata_i,
  output logic [NUM_BANKS-1:0] gate_o
);
  logic we_gate;
  assign we_gate = reg_we_i && (int'(reg_addr_i) == GATE_ADDR);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      gate_o <= '0;
    else if (we_gate) gate_o <= reg_wdata_i[NUM_BANKS-1:0];
  end

  a_r7_gate_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_gate |=> $stable(gate_o));
endmodule

// File: rtl/irq_agg_rdmux.sv
module irq_agg_rdmux
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned GATE_ADDR = 8
) (
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic [NUM_BANKS*BANK_W-1:0] en_i,
  input  logic [NUM_BANKS*BANK_W-1:0] res_i,
  input  logic [NUM_BANKS-1:0]        gate_i,
  output logic [BANK_W-1:0]           rdata_o
);
  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (int'(addr_i) == b*REGS_PER_BANK + OFF_SRC) rdata_o = src_i[b*BANK_W +: BANK_W];
      if (int'(addr_i) == b*REGS_PER_BANK + OFF_SET) rdata_o = en_i[b*BANK_W +: BANK_W];
      if (int'(addr_i) == b*REGS_PER_BANK + OFF_CLR) rdata_o = en_i[b*BANK_W +: BANK_W];
      if (int'(addr_i) == b*REGS_PER_BANK + OFF_RES) rdata_o = res_i[b*BANK_W +: BANK_W];
    end
    if (int'(addr_i) == GATE_ADDR) rdata_o[NUM_BANKS-1:0] = gate_i;
  end
endmodule

// File: rtl/irq_bank_agg.sv
module irq_bank_agg
  import irq_agg_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 2,
  parameter int unsigned BANK_W    = 32,
  localparam int unsigned GATE_ADDR = NUM_BANKS * REGS_PER_BANK,
  localparam int unsigned ADDR_W    = $clog2(GATE_ADDR + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        reg_we_i,
  input  logic [ADDR_W-1:0]           reg_addr_i,
  input  logic [BANK_W-1:0]           reg_wdata_i,
  output logic [BANK_W-1:0]           reg_rdata_o,
  input  logic [NUM_BANKS*BANK_W-1:0] evt_i,
  output logic [NUM_BANKS-1:0]        irq_o
);
  logic [NUM_BANKS-1:0]        gate;
  logic [NUM_BANKS*BANK_W-1:0] src_all, en_all, res_all;

  irq_agg_gate #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .GATE_ADDR(GATE_ADDR)
  ) i_gate (
    .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i, .gate_o(gate)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    irq_agg_bank #(
      .BANK_W(BANK_W), .ADDR_W(ADDR_W), .BANK_IDX(b)
    ) i_bank (
      .clk_i, .rst_ni, .reg_we_i, .reg_addr_i, .reg_wdata_i,
      .evt_i (evt_i[b*BANK_W +: BANK_W]),
      .gate_i(gate[b]),
      .src_o (src_all[b*BANK_W +: BANK_W]),
      .en_o  (en_all[b*BANK_W +: BANK_W]),
      .res_o (res_all[b*BANK_W +: BANK_W]),
      .irq_o (irq_o[b])
    );

    a_r8_irq_follows_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (gate[b] && (|res_all[b*BANK_W +: BANK_W])) |-> irq_o[b]);
    a_r7_irq_needs_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[b] |-> gate[b]);
  end

  irq_agg_rdmux #(
    .NUM_BANKS(NUM_BANKS), .BANK_W(BANK_W), .ADDR_W(ADDR_W), .GATE_ADDR(GATE_ADDR)
  ) i_rdmux (
    .addr_i(reg_addr_i), .src_i(src_all), .en_i(en_all), .res_i(res_all),
    .gate_i(gate), .rdata_o(reg_rdata_o)
  );
endmodule

// File: tb/test_irq_bank_agg.sv
module test_irq_bank_agg;
  localparam int CLK_P = 10;
  localparam int NB = 2;
  localparam int W  = 32;
  localparam int AW = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata;
  logic [NB*W-1:0] evt = '0;
  logic [NB-1:0] irq;
  int checks = 0, fails = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  irq_bank_agg #(.NUM_BANKS(NB), .BANK_W(W)) i_irq_bank_agg (
    .clk_i(clk), .rst_ni(rst_ni), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .evt_i(evt), .irq_o(irq)
  );

  task automatic chk(string tag, logic [W-1:0] got, logic [W-1:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(int a, logic [W-1:0] d);
    @(negedge clk); we = 1'b1; addr = AW'(a); wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic rd(int a, output logic [W-1:0] d);
    @(negedge clk); addr = AW'(a); #1; d = rdata;
  endtask

  task automatic pulse(int bank, logic [W-1:0] m);
    @(negedge clk); evt[bank*W +: W] = m;
    @(negedge clk); evt = '0;
  endtask

  task automatic t_reset();
    logic [W-1:0] d;
    for (int a = 0; a <= 4*NB; a++) begin
      rd(a, d); chk("R1 reset reg", d, '0);
    end
    chk("R1 reset irq", W'(irq), '0);
  endtask

  task automatic t_latch_masked();
    logic [W-1:0] d;
    pulse(0, 32'h8000_0011);
    rd(0, d); chk("R2 latch with enable off", d, 32'h8000_0011);
    rd(3, d); chk("R6 result masked", d, '0);
    pulse(0, 32'h0000_0100);
    rd(0, d); chk("R2 sticky accumulate", d, 32'h8000_0111);
  endtask

  task automatic t_ack();
    logic [W-1:0] d;
    wr(0, 32'h0);
    rd(0, d); chk("R3 zero write no effect", d, 32'h8000_0111);
    wr(0, 32'h0000_0010);
    rd(0, d); chk("R3 w1c single", d, 32'h8000_0101);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R3 all ones clears", d, '0);
  endtask

  task automatic t_collide();
    logic [W-1:0] d;
    pulse(0, 32'h0000_0060);
    @(negedge clk);
    we = 1'b1; addr = AW'(0); wdata = 32'h0000_0060; evt[0 +: W] = 32'h0000_0020;
    @(negedge clk);
    we = 1'b0; wdata = '0; evt = '0;
    rd(0, d); chk("R4 event beats clear", d, 32'h0000_0020);
    wr(0, 32'hFFFF_FFFF);
  endtask

  task automatic t_enable();
    logic [W-1:0] d;
    wr(1, 32'h0000_F00F);
    rd(1, d); chk("R5 set readback", d, 32'h0000_F00F);
    wr(1, 32'h0);
    rd(2, d); chk("R5 clr addr readback", d, 32'h0000_F00F);
    wr(2, 32'h0000_0003);
    rd(1, d); chk("R5 clr partial", d, 32'h0000_F00C);
    wr(1, 32'h0000_0100);
    rd(2, d); chk("R5 set keeps others", d, 32'h0000_F10C);
    pulse(0, 32'h0000_1104);
    rd(3, d); chk("R6 result is and", d, 32'h0000_1104);
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); chk("R6 result write ignored", d, 32'h0000_1104);
    rd(0, d); chk("R6 result write leaves source", d, 32'h0000_1104);
  endtask

  task automatic t_gate();
    logic [W-1:0] d;
    @(negedge clk); chk("R7 irq low without gate", W'(irq[0]), 32'h0);
    wr(4*NB, 32'h1);
    rd(4*NB, d); chk("R7 gate readback", d, 32'h1);
    chk("R7 irq high with gate", W'(irq[0]), 32'h1);
    chk("R9 other bank quiet", W'(irq[1]), 32'h0);
  endtask

  task automatic t_reassert();
    wr(0, 32'h0000_0004);
    chk("R8 irq held after partial clear", W'(irq[0]), 32'h1);
    wr(0, 32'h0000_0100);
    chk("R8 irq held second clear", W'(irq[0]), 32'h1);
    @(negedge clk); we = 1'b1; addr = AW'(0); wdata = 32'h0000_1000;
    #1; chk("R8 irq high before last clear edge", W'(irq[0]), 32'h1);
    @(negedge clk); we = 1'b0; wdata = '0;
    chk("R8 irq drops after last clear", W'(irq[0]), 32'h0);
    pulse(0, 32'h0000_0008);
    chk("R8 irq back on new enabled event", W'(irq[0]), 32'h1);
    wr(4*NB, 32'h0);
    chk("R7 gate off drops irq", W'(irq[0]), 32'h0);
  endtask

  task automatic t_banks();
    logic [W-1:0] d;
    pulse(1, 32'hA5A5_0000);
    rd(4, d); chk("R9 bank1 source", d, 32'hA5A5_0000);
    rd(0, d); chk("R9 bank0 untouched", d, 32'h0000_0008);
    wr(5, 32'h0001_0000);
    rd(1, d); chk("R9 bank0 enable untouched", d, 32'h0000_F10C);
    wr(4*NB, 32'h2);
    chk("R9 bank1 irq", W'(irq[1]), 32'h1);
    chk("R9 bank0 irq gated", W'(irq[0]), 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_latch_masked();
    t_ack();
    t_collide();
    t_enable();
    t_gate();
    t_reassert();
    t_banks();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule